// File: doc/BRIEF.md
# Flow-through zero-turnaround synchronous SRAM

This block is a synthesizable model of a single-clock synchronous SRAM whose data bus can carry a read in one cycle and a write in the next with no idle cycle in between. Every control input is sampled on the rising clock edge. A command (read, write or deselect) is chosen only when a new address is loaded. A write takes its data one enabled edge after its address (late write), so read data and write data occupy the bus in the same order as their commands. Read data appears in the cycle right after the edge that loaded the read address. It comes from a registered array read with no further output stage.

After a load, the block can continue on its own. A 2-bit counter steps the two low address bits through four accesses, in linear or interleaved order. The high address bits stay fixed. Each byte lane has its own active-low write enable. A write whose lanes are all disabled does nothing. If a read is loaded on the same edge that commits a write to the same address, the read returns the newly written bytes. A stall input freezes the whole block for as many edges as it is held.

Top module: `ztsram`

## Requirements
- R1: A synchronous reset (rst high on an edge) leaves the block deselected: rdata_vld is 0 and rdata is all zeros after that edge.
- R2: An edge with stall=0, load_n=0, sel_a_n=0, sel_b_n=0, sel_c=1 and wr_n=1 loads a read. Right after that edge, rdata_vld is 1 and rdata holds the array word at addr.
- R3: An edge with load_n=0, all three selects passing and wr_n=0 loads a write. It captures addr and byte_en_n. The word is written at the next enabled edge from wdata. Byte lane k (bits k*BYTE_W and up) is updated only if byte_en_n[k] was 0. If every byte_en_n bit is 1, the array is left unchanged.
- R4: A read loaded on the same edge that commits a write to the same address returns the new bytes in the written lanes and the old bytes in the others.
- R5: With order_ilv=0, each enabled edge with load_n=1 moves the burst to the next word. The two low address bits count start, start+1, start+2, start+3 modulo 4, and the fifth access returns to the start. The high bits do not change.
- R6: With order_ilv=1, the low address bits of the n-th access (n = 0..3) are start XOR n.
- R7: On an edge with load_n=1, wr_n and the three selects are ignored. A burst keeps the read or write type chosen at load time.
- R8: A load on which sel_a_n=1, sel_b_n=1 or sel_c=0 deselects the block: rdata_vld=0, rdata=0 and no write. Further edges with load_n=1 keep it deselected, and any write data given on them is discarded.
- R9: On an edge with stall=1, nothing changes: no array write, no new command, no burst step. rdata and rdata_vld hold their values. Pending write data is taken at the next edge with stall=0.
- R10: During write cycles (including aborted writes), rdata_vld is 0 and rdata is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | 1 = ignore this edge and hold all state |
| load_n | input | 1 | 0 = load a new address and command, 1 = continue the burst |
| sel_a_n | input | 1 | Active-low select, sampled on load |
| sel_b_n | input | 1 | Second active-low select, sampled on load |
| sel_c | input | 1 | Active-high select, sampled on load |
| wr_n | input | 1 | 0 = write, 1 = read, sampled on load |
| byte_en_n | input | NUM_BYTES | Active-low per-lane write enables, given with the address |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTE_W*NUM_BYTES | Write data, one enabled edge after its address |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; change only while idle |
| rdata | output | BYTE_W*NUM_BYTES | Read data, zero when not driving |
| rdata_vld | output | 1 | 1 while a read cycle drives rdata |

## Verification
Two things can happen on one edge: a write's late data is committed, and a read of the same address is loaded. The bench provokes this in two ways. First, a partial-lane write is followed at once by a read of its address. Second, a write whose data edge was delayed by a stall is followed by a read of its address. In both cases the returned word must merge new and old bytes exactly as the enables say. A stall in the middle of a read burst also tests that the burst position and the driven data stay frozen, and that the burst then resumes at the next word.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of burst access number cnt from start value base.
  function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/ztsram_seq.sv
module ztsram_seq
  import ztsram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 load_n,
  input  logic                 sel_a_n,
  input  logic                 sel_b_n,
  input  logic                 sel_c,
  input  logic                 wr_n,
  input  logic [NUM_BYTES-1:0] byte_en_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 order_ilv,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [NUM_BYTES-1:0] wr_mask,
  output logic                 rd_active
);

  localparam int HI_W = ADDR_W - 2;

  op_e                  op_q;
  logic [HI_W-1:0]      hi_q;
  logic [1:0]           base_q;
  logic [1:0]           cnt_q;
  logic [NUM_BYTES-1:0] mask_q;
  logic [1:0]           cnt_nx;
  logic                 sel_ok;

  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;
  assign cnt_nx = cnt_q + 2'd1;

  // The address of the operation in flight, and the one the array looks up
  // at the coming edge (lookahead lets the read port be synchronous).
  assign wr_addr   = {hi_q, burst_lsb(base_q, cnt_q, order_ilv)};
  assign rd_addr   = load_n ? {hi_q, burst_lsb(base_q, cnt_nx, order_ilv)} : addr;
  assign wr_mask   = (op_q == OP_WRITE) ? mask_q : '0;
  assign rd_active = (op_q == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (!stall) begin
      mask_q <= ~byte_en_n;
      if (!load_n) begin
        op_q   <= sel_ok ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
        hi_q   <= addr[ADDR_W-1:2];
        base_q <= addr[1:0];
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/ztsram_lane.sv
module ztsram_lane #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] wd,
  input  logic              out_en,
  output logic [BYTE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rd_q;
  logic [BYTE_W-1:0] byp_d;
  logic              byp_q;

  // Plain one-write one-read memory with a registered read: block RAM shape.
  always_ff @(posedge clk) begin
    if (!stall) begin
      if (we) mem[wr_addr] <= wd;
      rd_q  <= mem[rd_addr];
      byp_d <= wd;
    end
  end

  // The RAM returns old data on a same-address collision; remember it.
  always_ff @(posedge clk) begin
    if (rst)         byp_q <= 1'b0;
    else if (!stall) byp_q <= we && (wr_addr == rd_addr);
  end

  assign rd = out_en ? (byp_q ? byp_d : rd_q) : '0;

endmodule

// File: rtl/ztsram.sv
module ztsram #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        stall,
  input  logic                        load_n,
  input  logic                        sel_a_n,
  input  logic                        sel_b_n,
  input  logic                        sel_c,
  input  logic                        wr_n,
  input  logic [NUM_BYTES-1:0]        byte_en_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W*NUM_BYTES-1:0] wdata,
  input  logic                        order_ilv,
  output logic [BYTE_W*NUM_BYTES-1:0] rdata,
  output logic                        rdata_vld
);

  localparam int DATA_W = BYTE_W * NUM_BYTES;

  logic [ADDR_W-1:0]    rd_addr;
  logic [ADDR_W-1:0]    wr_addr;
  logic [NUM_BYTES-1:0] wr_mask;
  logic                 rd_active;

  ztsram_seq #(
    .ADDR_W    (ADDR_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .load_n    (load_n),
    .sel_a_n   (sel_a_n),
    .sel_b_n   (sel_b_n),
    .sel_c     (sel_c),
    .wr_n      (wr_n),
    .byte_en_n (byte_en_n),
    .addr      (addr),
    .order_ilv (order_ilv),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .wr_mask   (wr_mask),
    .rd_active (rd_active)
  );

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    ztsram_lane #(
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .stall   (stall),
      .we      (wr_mask[g]),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .wd      (wdata[g*BYTE_W +: BYTE_W]),
      .out_en  (rd_active),
      .rd      (rdata[g*BYTE_W +: BYTE_W])
    );
  end

  assign rdata_vld = rd_active;

endmodule

// File: rtl/ztsram_chk.sv
module ztsram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              load_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              wr_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_vld
);

  logic sel_ok;
  assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !rdata_vld);

  assert_read_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !load_n && sel_ok && wr_n) |=> rdata_vld);

  assert_continue_keeps_type_R7: assert property (@(posedge clk) disable iff (rst)
    (!stall && load_n) |=> $stable(rdata_vld));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!stall && !load_n && !sel_ok) |=> !rdata_vld);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(rdata) && $stable(rdata_vld)));

  assert_write_bus_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!stall && !load_n && sel_ok && !wr_n) |=> !rdata_vld);

endmodule

bind ztsram ztsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .load_n    (load_n),
  .sel_a_n   (sel_a_n),
  .sel_b_n   (sel_b_n),
  .sel_c     (sel_c),
  .wr_n      (wr_n),
  .rdata     (rdata),
  .rdata_vld (rdata_vld)
);

// File: tb/test_ztsram.sv
module test_ztsram;

  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 4;
  localparam int ADDR_W     = 6;
  localparam int DW         = BYTE_W * NUM_BYTES;
  localparam logic [2:0] OK = 3'b001;   // {sel_a_n, sel_b_n, sel_c}

  typedef struct packed {
    logic          ld_n;
    logic [2:0]    sel;
    logic          wr_n;
    logic [3:0]    be_n;
    logic [5:0]    a;
    logic [31:0]   wd;
    logic          stl;
    logic          ev;
    logic [31:0]   er;
    logic [3:0]    req;
  } vec_t;

  function automatic vec_t v(logic ld_n, logic [2:0] sel, logic wr_n,
                             logic [3:0] be_n, logic [5:0] a, logic [31:0] wd,
                             logic stl, logic ev, logic [31:0] er, logic [3:0] req);
    vec_t r;
    r = '{ld_n, sel, wr_n, be_n, a, wd, stl, ev, er, req};
    return r;
  endfunction

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    v(0, OK,     0, 4'b0000, 6'h10, 32'h0,        0, 0, 32'h0,        4'd10), // R10 write load
    v(0, OK,     0, 4'b0000, 6'h11, 32'hA0A00010, 0, 0, 32'h0,        4'd10), // R3 data for 0x10
    v(1, OK,     1, 4'b0000, 6'h00, 32'hA0A00011, 0, 0, 32'h0,        4'd7),  // R7 wr_n ignored
    v(1, OK,     0, 4'b0000, 6'h00, 32'hA0A00012, 0, 0, 32'h0,        4'd5),  // R5 write burst
    v(0, OK,     1, 4'b0000, 6'h10, 32'hA0A00013, 0, 1, 32'hA0A00010, 4'd2),  // R2 read
    v(1, OK,     1, 4'b0000, 6'h00, 32'h0,        0, 1, 32'hA0A00011, 4'd5),  // R5
    v(1, OK,     1, 4'b0000, 6'h00, 32'h0,        0, 1, 32'hA0A00012, 4'd5),  // R5
    v(1, OK,     1, 4'b0000, 6'h00, 32'h0,        0, 1, 32'hA0A00013, 4'd5),  // R5
    v(1, OK,     1, 4'b0000, 6'h00, 32'h0,        0, 1, 32'hA0A00010, 4'd5),  // R5 wrap
    v(0, OK,     0, 4'b1010, 6'h10, 32'h0,        0, 0, 32'h0,        4'd3),  // R3 lanes 0,2
    v(0, OK,     1, 4'b0000, 6'h10, 32'h11223344, 0, 1, 32'hA0220044, 4'd4),  // R4 bypass
    v(0, OK,     1, 4'b0000, 6'h10, 32'h0,        0, 1, 32'hA0220044, 4'd3),  // R3 from array
    v(0, OK,     0, 4'b1111, 6'h11, 32'h0,        0, 0, 32'h0,        4'd3),  // R3 abort
    v(0, OK,     1, 4'b0000, 6'h11, 32'hFFFFFFFF, 0, 1, 32'hA0A00011, 4'd3),  // R3 unchanged
    v(0, 3'b101, 0, 4'b0000, 6'h11, 32'h0,        0, 0, 32'h0,        4'd8),  // R8 sel_a_n
    v(1, OK,     0, 4'b0000, 6'h11, 32'hDEADBEEF, 0, 0, 32'h0,        4'd8),  // R8 continue
    v(0, OK,     1, 4'b0000, 6'h11, 32'h0,        0, 1, 32'hA0A00011, 4'd8),  // R8 no write
    v(0, 3'b000, 1, 4'b0000, 6'h11, 32'h0,        0, 0, 32'h0,        4'd8),  // R8 sel_c
    v(0, 3'b011, 1, 4'b0000, 6'h11, 32'h0,        0, 0, 32'h0,        4'd8),  // R8 sel_b_n
    v(0, OK,     1, 4'b0000, 6'h12, 32'h0,        0, 1, 32'hA0A00012, 4'd2),  // R2
    v(1, 3'b000, 0, 4'b0000, 6'h00, 32'h0BAD0BAD, 0, 1, 32'hA0A00013, 4'd7),  // R7
    v(0, OK,     0, 4'b0000, 6'h10, 32'h0,        1, 1, 32'hA0A00013, 4'd9),  // R9 stall
    v(0, OK,     0, 4'b0000, 6'h10, 32'h0,        1, 1, 32'hA0A00013, 4'd9),  // R9 stall
    v(1, OK,     1, 4'b0000, 6'h00, 32'h0,        0, 1, 32'hA0220044, 4'd9),  // R9 resume
    v(0, OK,     0, 4'b0000, 6'h12, 32'h0,        0, 0, 32'h0,        4'd10), // R10
    v(0, OK,     1, 4'b0000, 6'h13, 32'h12345678, 1, 0, 32'h0,        4'd9),  // R9 data held
    v(0, OK,     1, 4'b0000, 6'h12, 32'hCAFE0012, 0, 1, 32'hCAFE0012, 4'd4),  // R4 after stall
    v(0, OK,     1, 4'b0000, 6'h12, 32'h0,        0, 1, 32'hCAFE0012, 4'd9)   // R9
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 stall;
  logic                 load_n;
  logic                 sel_a_n, sel_b_n, sel_c;
  logic                 wr_n;
  logic [NUM_BYTES-1:0] byte_en_n;
  logic [ADDR_W-1:0]    addr;
  logic [DW-1:0]        wdata;
  logic                 order_ilv;
  logic [DW-1:0]        rdata;
  logic                 rdata_vld;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ztsram #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W)
  ) i_ztsram (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .load_n    (load_n),
    .sel_a_n   (sel_a_n),
    .sel_b_n   (sel_b_n),
    .sel_c     (sel_c),
    .wr_n      (wr_n),
    .byte_en_n (byte_en_n),
    .addr      (addr),
    .wdata     (wdata),
    .order_ilv (order_ilv),
    .rdata     (rdata),
    .rdata_vld (rdata_vld)
  );

  task automatic step(input logic ld_n, input logic [2:0] sel, input logic w_n,
                      input logic [3:0] be, input logic [5:0] a,
                      input logic [31:0] wd, input logic stl);
    @(negedge clk);
    load_n    = ld_n;
    {sel_a_n, sel_b_n, sel_c} = sel;
    wr_n      = w_n;
    byte_en_n = be;
    addr      = a;
    wdata     = wd;
    stall     = stl;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string tag, input logic ev, input logic [31:0] er);
    checks++;
    if (rdata_vld !== ev || rdata !== er) begin
      errors++;
      $display("FAIL %s: vld=%0b rdata=%h expected vld=%0b rdata=%h",
               tag, rdata_vld, rdata, ev, er);
    end
  endtask

  initial begin
    rst = 1'b1; stall = 1'b0; load_n = 1'b1; {sel_a_n, sel_b_n, sel_c} = OK;
    wr_n = 1'b1; byte_en_n = '1; addr = '0; wdata = '0; order_ilv = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset", 1'b0, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: each row is one edge, checked just after it.
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ld_n, TBL[i].sel, TBL[i].wr_n, TBL[i].be_n,
           TBL[i].a, TBL[i].wd, TBL[i].stl);
      check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].ev, TBL[i].er);
    end

    // R6 interleaved bursts from start 10 and start 01.
    @(negedge clk);
    order_ilv = 1'b1;
    step(0, OK, 1, 4'b0000, 6'h12, 32'h0, 0); check("R6 start 0x12", 1, 32'hCAFE0012);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 2nd 0x13",   1, 32'hA0A00013);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 3rd 0x10",   1, 32'hA0220044);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 4th 0x11",   1, 32'hA0A00011);
    step(0, OK, 1, 4'b0000, 6'h11, 32'h0, 0); check("R6 start 0x11", 1, 32'hA0A00011);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 2nd 0x10",   1, 32'hA0220044);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 3rd 0x13",   1, 32'hA0A00013);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 4th 0x12",   1, 32'hCAFE0012);
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R6 wrap 0x11",  1, 32'hA0A00011);

    // R1 reset in the middle of a read burst.
    @(negedge clk);
    rst = 1'b1; load_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset mid-burst", 1'b0, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    step(1, OK, 1, 4'b0000, 6'h00, 32'h0, 0); check("R1 idle after reset", 1'b0, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycles=5000 expected fewer");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule